// File: doc/BRIEF.md
# Two-Wire Slave Register Access Engine

This block is a two-wire serial slave that opens a small file of 8-bit configuration registers to a bus master. It oversamples the clock and data lines on the system clock and finds START, repeated START and STOP conditions. It answers one of two 7-bit device addresses, chosen by a strap input. The first byte of a write transfer loads an internal register pointer. Every later byte goes to the register the pointer selects. A read transfer returns bytes from the pointer onward. The pointer steps after every data byte and wraps past the last register.

The register contents are presented in parallel to the neighbouring GPIO and interrupt logic. The block also gives a write strobe for each byte it commits and a read strobe for each byte it fetches. Both strobes carry the register index. Three registers are only a nibble wide. A START or STOP that arrives in the middle of a byte throws that byte away.

Top module: `twi_reg_slave`

## Requirements
- R1: The slave acknowledges, by pulling SDA low during the 9th clock, only the address 0001000 when addr_sel_i is 0 and 0001111 when it is 1, with the R/W bit as the 8th bit (1 = read). On any other address it leaves SDA released, changes no register and ignores the bus until the next START.
- R2: In a write transfer, the first byte after the address loads the pointer from its low 4 bits. Each later byte is stored in the register the pointer selects.
- R3: The pointer advances by one after every data byte written or read, and steps from 9 back to 0.
- R4: A pointer byte whose low 4 bits exceed 9 sets the pointer to 0.
- R5: A read transfer with no preceding pointer byte starts at the register after the last one written or read. After reset it starts at register 0.
- R6: A write of the pointer byte, then a repeated START and a read address, reads from the newly loaded pointer.
- R7: A STOP or a repeated START in the middle of the address byte or a data byte discards that byte. No register changes and the pointer does not move.
- R8: Registers 2, 5 and 8 keep only their low 4 bits. Writes drop the upper nibble, and reads and regs_o return it as zero.
- R9: After the master answers a read byte with NACK, the slave keeps SDA released for every further clock until the next START.
- R10: Reset values, register 0 upward: FF, FF, 0F, 00, 00, 00, FF, FF, 0F, 03. After reset SDA is released.
- R11: wr_stb_o pulses once for each committed data byte, and rd_stb_o pulses once for each byte loaded for reading. Pointer bytes give no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, well above the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel_i | input | 1 | Strap that selects the device address |
| sda_pull_o | output | 1 | High pulls SDA low |
| wr_stb_o | output | 1 | Pulse for a committed register write |
| rd_stb_o | output | 1 | Pulse for a register fetch for reading |
| reg_idx_o | output | 4 | Register index for the current strobe |
| wr_data_o | output | 8 | Byte written with wr_stb_o |
| regs_o | output | 80 | All register contents, register i at bits [8i+7:8i] |

## Verification
The bench uses the default parameters: ten 8-bit registers, device addresses 08h and 0Fh, and nibble registers at 2, 5 and 8. With a 4-bit pointer field, these defaults let pointer bytes 0Ah to 0Fh test the forced-to-zero rule. Short bursts starting at 8 or 9 cross the wrap point. The bench drives both strap settings, so it also sends each device's address to the other one. Aborts are placed in the address byte and in a data byte. Random mixes of writes, bare reads and combined reads then follow a reference model of the pointer across transfers.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WR,
    ST_RD,
    ST_RACK
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA moving while SCL stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
  parameter int DW = 8,
  parameter int NUM_REGS = 10,
  parameter int IW = 4,
  parameter logic [NUM_REGS-1:0] NARROW_MASK = '0,
  parameter logic [NUM_REGS*DW-1:0] RESET_VAL = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IW-1:0]          wr_idx_i,
  input  logic [DW-1:0]          wr_data_i,
  input  logic [IW-1:0]          rd_idx_i,
  output logic [DW-1:0]          rd_data_o,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  localparam logic [DW-1:0] LOW_HALF = {DW{1'b1}} >> (DW/2);

  logic [NUM_REGS*DW-1:0] regs_flat;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DW-1:0] KEEP = NARROW_MASK[g] ? LOW_HALF : {DW{1'b1}};
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RESET_VAL[g*DW +: DW] & KEEP;
      else if (wr_en_i && wr_idx_i == IW'(g)) q <= wr_data_i & KEEP;
    end
    assign regs_flat[g*DW +: DW] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx_i == IW'(i)) rd_data_o = regs_flat[i*DW +: DW];
    end
  end

  assign regs_o = regs_flat;

  a_r4_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_idx_i) < NUM_REGS));
endmodule

// File: rtl/twi_link_fsm.sv
module twi_link_fsm
  import twi_pkg::*;
#(
  parameter int DW = 8,
  parameter int NUM_REGS = 10,
  parameter int IW = 4,
  parameter logic [DW-2:0] DEV_ADDR0 = 'h08,
  parameter logic [DW-2:0] DEV_ADDR1 = 'h0F
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          addr_sel_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [IW-1:0] ptr_o,
  output logic          sda_pull_o,
  output logic          wr_stb_o,
  output logic          rd_stb_o,
  output logic [IW-1:0] idx_o,
  output logic [DW-1:0] wdata_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  twi_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;
  logic [IW-1:0] ptr_q;
  logic          rw_q, ptr_pend_q, mack_q, pull_q;
  logic [DW-2:0] dev_addr;

  assign dev_addr = addr_sel_i ? DEV_ADDR1 : DEV_ADDR0;

  function automatic logic [IW-1:0] ptr_step(input logic [IW-1:0] p);
    return (int'(p) == NUM_REGS - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      ptr_q      <= '0;
      rw_q       <= 1'b0;
      ptr_pend_q <= 1'b0;
      mack_q     <= 1'b0;
      pull_q     <= 1'b0;
      wr_stb_o   <= 1'b0;
      rd_stb_o   <= 1'b0;
      idx_o      <= '0;
      wdata_o    <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      rd_stb_o <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i && cnt_q < FULL) begin
              sh_q  <= {sh_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              if (sh_q[DW-1:1] == dev_addr) begin
                pull_q     <= 1'b1;
                rw_q       <= sh_q[0];
                ptr_pend_q <= ~sh_q[0];
                state_q    <= ST_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                sh_q     <= rd_data_i;
                pull_q   <= ~rd_data_i[DW-1];
                rd_stb_o <= 1'b1;
                idx_o    <= ptr_q;
                state_q  <= ST_RD;
              end else begin
                pull_q  <= 1'b0;
                state_q <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise_i && cnt_q < FULL) begin
              sh_q  <= {sh_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              pull_q  <= 1'b1;
              state_q <= ST_ACK;
              if (ptr_pend_q) begin
                ptr_pend_q <= 1'b0;
                ptr_q <= (int'(sh_q[IW-1:0]) < NUM_REGS) ? sh_q[IW-1:0] : '0;
              end else begin
                wr_stb_o <= 1'b1;
                idx_o    <= ptr_q;
                wdata_o  <= sh_q;
                ptr_q    <= ptr_step(ptr_q);
              end
            end
          end
          ST_RD: begin
            if (scl_fall_i) begin
              if (cnt_q == LAST) begin
                pull_q  <= 1'b0;
                ptr_q   <= ptr_step(ptr_q);
                state_q <= ST_RACK;
              end else begin
                sh_q   <= {sh_q[DW-2:0], 1'b0};
                pull_q <= ~sh_q[DW-2];
                cnt_q  <= cnt_q + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) mack_q <= ~sda_i;
            else if (scl_fall_i) begin
              if (mack_q) begin
                cnt_q    <= '0;
                sh_q     <= rd_data_i;
                pull_q   <= ~rd_data_i[DW-1];
                rd_stb_o <= 1'b1;
                idx_o    <= ptr_q;
                state_q  <= ST_RD;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o      = ptr_q;
  assign sda_pull_o = pull_q;

  a_r1_addr_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR) |-> !pull_q);
  a_r9_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !pull_q);
  a_r7_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_ADDR));
  a_r7_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (state_q == ST_IDLE));
  a_r3_ptr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ptr_q) < NUM_REGS);
  a_r11_wr_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(state_q == ST_WR));
  a_r11_rd_stb_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_o |-> (state_q == ST_RD));
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter int DW = 8,
  parameter int NUM_REGS = 10,
  parameter int SYNC_STAGES = 2,
  parameter logic [DW-2:0] DEV_ADDR0 = 'h08,
  parameter logic [DW-2:0] DEV_ADDR1 = 'h0F,
  parameter logic [NUM_REGS-1:0] NARROW_MASK = 10'b01_0010_0100,
  parameter logic [NUM_REGS*DW-1:0] RESET_VAL =
    {8'h03, 8'h0F, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hFF, 8'hFF},
  localparam int IW = $clog2(NUM_REGS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic                   addr_sel_i,
  output logic                   sda_pull_o,
  output logic                   wr_stb_o,
  output logic                   rd_stb_o,
  output logic [IW-1:0]          reg_idx_o,
  output logic [DW-1:0]          wr_data_o,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  logic          sda_s, scl_rise, scl_fall, start, stop;
  logic [IW-1:0] ptr;
  logic [DW-1:0] rd_data;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  twi_link_fsm #(
    .DW(DW), .NUM_REGS(NUM_REGS), .IW(IW),
    .DEV_ADDR0(DEV_ADDR0), .DEV_ADDR1(DEV_ADDR1)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .addr_sel_i (addr_sel_i),
    .rd_data_i  (rd_data),
    .ptr_o      (ptr),
    .sda_pull_o (sda_pull_o),
    .wr_stb_o   (wr_stb_o),
    .rd_stb_o   (rd_stb_o),
    .idx_o      (reg_idx_o),
    .wdata_o    (wr_data_o)
  );

  twi_regfile #(
    .DW(DW), .NUM_REGS(NUM_REGS), .IW(IW),
    .NARROW_MASK(NARROW_MASK), .RESET_VAL(RESET_VAL)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_stb_o),
    .wr_idx_i  (reg_idx_o),
    .wr_data_i (wr_data_o),
    .rd_idx_i  (ptr),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );
endmodule

// File: tb/twi_reg_slave_bench.sv
module twi_reg_slave_bench;
  localparam int T = 4;
  localparam int NR = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_pull, wr_stb, rd_stb;
  logic [3:0] reg_idx;
  logic [7:0] wr_data;
  logic [NR*8-1:0] regs;
  wire sda_line = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  twi_reg_slave u_twi_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .sda_pull_o(sda_pull), .wr_stb_o(wr_stb),
    .rd_stb_o(rd_stb), .reg_idx_o(reg_idx), .wr_data_o(wr_data), .regs_o(regs)
  );

  int n_tests = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0;
  bit done = 1'b0;
  logic [7:0] m [NR];
  int ptr = 0;
  logic [7:0] wbuf [16];

  always @(posedge clk) begin
    if (wr_stb) wr_cnt++;
    if (rd_stb) rd_cnt++;
  end

  function automatic logic [7:0] keep(input int i);
    return (i == 2 || i == 5 || i == 8) ? 8'h0F : 8'hFF;
  endfunction
  function automatic int step(input int p);
    return (p == NR - 1) ? 0 : p + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(T); scl = 1'b1; tick(T); sda_m = 1'b0; tick(T); scl = 1'b0; tick(T);
  endtask
  task automatic i2c_stop();
    sda_m = 1'b0; tick(T); scl = 1'b1; tick(T); sda_m = 1'b1; tick(T);
  endtask
  task automatic send_bit(input logic b);
    sda_m = b; tick(T); scl = 1'b1; tick(2*T); scl = 1'b0; tick(T);
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(T); scl = 1'b1; tick(T); b = sda_line; tick(T); scl = 1'b0; tick(T);
  endtask
  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(a);
    acked = !a;
  endtask
  task automatic recv_byte(input bit ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    send_bit(!ack);
  endtask

  function automatic logic [7:0] dev(input logic sel, input logic rw);
    return {(sel ? 7'h0F : 7'h08), rw};
  endfunction

  task automatic check_regs(input string req);
    for (int i = 0; i < NR; i++)
      check(regs[i*8 +: 8] == m[i], req, regs[i*8 +: 8], m[i]);
  endtask

  // pointer byte then n bytes from wbuf
  task automatic wr_txn(input logic [7:0] p, input int n);
    bit a;
    int w0;
    w0 = wr_cnt;
    i2c_start();
    send_byte(dev(addr_sel, 1'b0), a);
    check(a, "R1 addr ack", a, 1);
    send_byte(p, a);
    ptr = (int'(p[3:0]) < NR) ? int'(p[3:0]) : 0;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      check(a, "R2 data ack", a, 1);
      m[ptr] = wbuf[i] & keep(ptr);
      ptr = step(ptr);
    end
    i2c_stop();
    tick(4);
    check(wr_cnt - w0 == n, "R11 write strobes", wr_cnt - w0, n);
    check_regs("R2 R3 R4 R8 regs");
  endtask

  task automatic rd_txn(input bit comb, input logic [7:0] p, input int n, input string req);
    bit a;
    logic [7:0] v;
    int r0;
    r0 = rd_cnt;
    i2c_start();
    if (comb) begin
      send_byte(dev(addr_sel, 1'b0), a);
      send_byte(p, a);
      ptr = (int'(p[3:0]) < NR) ? int'(p[3:0]) : 0;
      i2c_start();
    end
    send_byte(dev(addr_sel, 1'b1), a);
    check(a, "R1 read addr ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, v);
      check(v == m[ptr], req, v, m[ptr]);
      ptr = step(ptr);
    end
    i2c_stop();
    tick(4);
    check(rd_cnt - r0 == n, "R11 read strobes", rd_cnt - r0, n);
  endtask

  initial begin
    bit a;
    logic b;
    logic [7:0] v;
    void'($urandom(32'd2024));
    m[0] = 8'hFF; m[1] = 8'hFF; m[2] = 8'h0F; m[3] = 8'h00; m[4] = 8'h00;
    m[5] = 8'h00; m[6] = 8'hFF; m[7] = 8'hFF; m[8] = 8'h0F; m[9] = 8'h03;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R10 reset state
    check_regs("R10 reset value");
    check(sda_pull == 1'b0, "R10 sda released", sda_pull, 0);
    // R5 bare read after reset starts at 0
    rd_txn(1'b0, 8'h00, 3, "R5 bare read after reset");
    // R2 R3 burst
    for (int i = 0; i < 5; i++) wbuf[i] = 8'hA0 + 8'(i * 17);
    wr_txn(8'h03, 5);
    // R3 R8 wrap across 9, other strap
    addr_sel = 1'b1;
    wbuf[0] = 8'hC7; wbuf[1] = 8'h5A; wbuf[2] = 8'h3C; wbuf[3] = 8'h96;
    wr_txn(8'h08, 4);
    // R4 pointer out of range, upper bits of pointer byte ignored
    wbuf[0] = 8'h42;
    wr_txn(8'h0C, 1);
    wbuf[0] = 8'hE5;
    wr_txn(8'hF5, 1);
    // R6 R8 combined read from narrow register
    rd_txn(1'b1, 8'h02, 4, "R6 R8 combined read");
    // R5 bare read continues
    rd_txn(1'b0, 8'h00, 3, "R5 bare read resumes");
    // R1 wrong strap: 08h addressed while strap selects 0Fh
    i2c_start();
    send_byte(8'h10, a);
    check(!a, "R1 foreign address nack", a, 0);
    send_byte(8'h00, a);
    send_byte(8'h99, a);
    check(!a, "R1 ignored after nack", a, 0);
    i2c_stop();
    tick(4);
    check_regs("R1 regs unchanged");
    addr_sel = 1'b0;
    i2c_start();
    send_byte(8'h50, a);
    check(!a, "R1 unknown address nack", a, 0);
    i2c_stop();
    // R7 stop mid data byte
    i2c_start();
    send_byte(dev(1'b0, 1'b0), a);
    send_byte(8'h04, a);
    ptr = 4;
    for (int i = 0; i < 5; i++) send_bit(i[0]);
    i2c_stop();
    tick(4);
    check_regs("R7 partial byte dropped");
    rd_txn(1'b0, 8'h00, 1, "R7 pointer kept after abort");
    // R7 repeated START mid data byte
    i2c_start();
    send_byte(dev(1'b0, 1'b0), a);
    send_byte(8'h06, a);
    send_byte(8'h11, a);
    m[6] = 8'h11;
    ptr = 7;
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    i2c_start();
    send_byte(dev(1'b0, 1'b1), a);
    recv_byte(1'b0, v);
    check(v == m[7], "R7 restart mid byte read", v, m[7]);
    ptr = 8;
    i2c_stop();
    tick(4);
    check_regs("R7 regs after restart");
    // R7 abort inside address byte, then normal access
    i2c_start();
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i2c_stop();
    rd_txn(1'b0, 8'h00, 2, "R7 recovery after address abort");
    // R9 NACK releases SDA
    i2c_start();
    send_byte(dev(1'b0, 1'b1), a);
    recv_byte(1'b0, v);
    check(v == m[ptr], "R9 last byte", v, m[ptr]);
    ptr = step(ptr);
    for (int i = 0; i < 9; i++) begin
      get_bit(b);
      check(b == 1'b1 && sda_pull == 1'b0, "R9 released after nack", b, 1);
    end
    i2c_stop();
    // random mix
    for (int it = 0; it < 30; it++) begin
      int op, n;
      logic [7:0] p;
      op = $urandom_range(0, 2);
      n = $urandom_range(1, 5);
      p = 8'($urandom_range(0, 255));
      addr_sel = 1'($urandom_range(0, 1));
      if (op == 0) begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom_range(0, 255));
        wr_txn(p, n);
      end else begin
        rd_txn(op == 1, p, n, "R3 R5 R6 random read");
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule